// File: doc/BRIEF.md
# Credit-Gated Frame Transmit Controller

This block sits on the transmit side of a serial storage-network port and decides what 32-bit word goes to the line encoder on every clock. It takes frames from a transmit buffer as 32-bit words over a valid/ready handshake. The first word of a frame carries a start flag and the last word carries an end flag. The block wraps each frame in a start delimiter, a CRC word and an end delimiter. Between frames it emits idle ordered sets, or receiver-ready primitives when some are queued. Each output word is tagged as either data or an ordered set, so a downstream 8b/10b encoder knows which first character to treat as a control code.

Frame starts are gated by buffer-to-buffer credit. A counter tracks frames sent but not yet acknowledged. Each frame start adds one, and each receiver-ready primitive arriving from the link partner removes one. A frame may begin only while that count is below a configured limit. The block also enforces a minimum run of fill words after every end delimiter before the next start delimiter can go out.

Top module: `frame_tx_sched`

## Requirements
- R1: After reset, the output is the idle word 32'hBC95B5B5 with `out_is_os`=1, and `in_ready` is 0 while `in_valid` is 0.
- R2: Each frame goes out as the start delimiter 32'hBCB5E6E6 (ordered set), then the accepted words in order (data), then the CRC word (data), then the end delimiter 32'hBC95F5F5 (ordered set).
- R3: A frame starts only while the outstanding count is strictly below `cfg_credit_limit`. With a limit of 0, no frame starts and `in_ready` stays 0 for a waiting start word.
- R4: The outstanding count rises by one at each start delimiter and falls by one for each cycle in which `rx_rrdy` is 1.
- R5: When a start and an `rx_rrdy` fall in the same cycle, the count is unchanged. An `rx_rrdy` at count 0 leaves the count at 0.
- R6: At least 6 fill words separate an end delimiter from the next start delimiter, and exactly 6 when the next frame is already waiting. No gap is needed after reset.
- R7: The CRC word is the bitwise inverse of a CRC-32 (polynomial 0x04C11DB7, register preset to all ones, each word fed most significant bit first) taken over all accepted frame words.
- R8: Each `tx_rrdy_req` pulse queues one receiver-ready word 32'hBC954949 (ordered set). Queued words go out in the gap ahead of idles and never between a start and an end delimiter.
- R9: A `link_reset` pulse clears the outstanding count to zero.
- R10: `in_ready` is 1 for the whole frame body. If the buffer stalls mid-frame, idle words are emitted as fill and the CRC does not change.
- R11: A valid word without the start flag, offered outside a frame, is accepted and discarded. It produces no output word and takes no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_credit_limit | input | CRED_W | Credit limit from configuration |
| link_reset | input | 1 | Clears the outstanding-frame count |
| rx_rrdy | input | 1 | Receiver-ready primitive received from the partner |
| tx_rrdy_req | input | 1 | Request to send one receiver-ready primitive |
| in_valid | input | 1 | Transmit buffer word valid |
| in_sof | input | 1 | Word is the first of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| in_data | input | 32 | Frame word |
| in_ready | output | 1 | Block accepts the offered word |
| out_word | output | 32 | Word for the line encoder |
| out_is_os | output | 1 | 1 when out_word is an ordered set, 0 for data |

## Verification
The bench checks the credit boundary from both sides. It confirms that a third frame waits at a limit of two until a receiver-ready arrives, and that a limit of zero never lets a frame start. A design whose comparison is off by one would send one frame too many or stall one too early. It also lines up a receiver-ready with a frame start in the same cycle, and sends receiver-readys while the count is zero. A design that let either event win, or that wrapped below zero, would later block frames that should start. The bench counts the fill words between back-to-back frames and expects exactly six, so a gap counter that stops one short or runs one long is caught. It also checks that a receiver-ready requested during a frame is held until after the end delimiter, which catches a design that leaks primitives into a frame.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  localparam int WORD_W = 32;

  localparam logic [WORD_W-1:0] OS_IDLE = 32'hBC95B5B5;
  localparam logic [WORD_W-1:0] OS_RRDY = 32'hBC954949;
  localparam logic [WORD_W-1:0] OS_SOF  = 32'hBCB5E6E6;
  localparam logic [WORD_W-1:0] OS_EOF  = 32'hBC95F5F5;
  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_BODY = 2'd1,
    ST_CRC  = 2'd2,
    ST_END  = 2'd3
  } ftx_state_e;

  // One full word folded into the CRC register in a single cycle,
  // most significant data bit entering first.
  function automatic logic [WORD_W-1:0] crc_fold(input logic [WORD_W-1:0] crc_in,
                                                 input logic [WORD_W-1:0] word);
    logic [WORD_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      fb = c[WORD_W-1] ^ word[b];
      c  = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/ftx_credit.sv
module ftx_credit #(
  parameter int CRED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_reset,
  input  logic              frame_start,
  input  logic              rrdy_in,
  input  logic [CRED_W-1:0] limit,
  output logic              credit_ok
);
  localparam logic [CRED_W-1:0] CNT_MAX = {CRED_W{1'b1}};

  logic [CRED_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (link_reset) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (frame_start && !rrdy_in) begin
      if (cnt_q != CNT_MAX) begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end else if (rrdy_in && !frame_start) begin
      if (cnt_q != '0) begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign credit_ok = (cnt_q < limit);

  p_credit_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (cnt_q < limit))
    else $error("frame started without credit");

  p_count_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !rrdy_in && !link_reset && cnt_q != CNT_MAX)
      |=> cnt_q == CRED_W'($past(cnt_q) + 1'b1))
    else $error("count did not rise on frame start");

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !frame_start) |=> cnt_q == '0 || $past(link_reset))
    else $error("count left zero without a start");

  p_both_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && rrdy_in && !link_reset) |=> $stable(cnt_q))
    else $error("simultaneous start and rrdy changed count");

  p_link_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_reset |=> cnt_q == '0)
    else $error("link reset did not clear count");
endmodule

// File: rtl/ftx_gap.sv
module ftx_gap #(
  parameter int GAP_MIN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic end_sent,
  input  logic fill_sent,
  output logic gap_done
);
  localparam int GW = $clog2(GAP_MIN + 1);
  localparam logic [GW-1:0] GAP_TOP = GW'(GAP_MIN);

  logic [GW-1:0] gap_q, gap_d;
  logic          gap_en;

  always_comb begin
    gap_d  = gap_q;
    gap_en = 1'b0;
    if (end_sent) begin
      gap_d  = '0;
      gap_en = 1'b1;
    end else if (fill_sent && gap_q != GAP_TOP) begin
      gap_d  = gap_q + 1'b1;
      gap_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= GAP_TOP;
    else if (gap_en) gap_q <= gap_d;
  end

  assign gap_done = (gap_q == GAP_TOP);

  p_gap_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_sent |=> !gap_done)
    else $error("gap reported done right after end delimiter");

  p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_done && !end_sent) |=> gap_done)
    else $error("gap done dropped without an end delimiter");
endmodule

// File: rtl/ftx_rrdy_queue.sv
module ftx_rrdy_queue #(
  parameter int RQ_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  output logic pending
);
  localparam logic [RQ_W-1:0] Q_MAX = {RQ_W{1'b1}};

  logic [RQ_W-1:0] q_q, q_d;
  logic            q_en;

  always_comb begin
    q_d  = q_q;
    q_en = 1'b0;
    if (req && !take && q_q != Q_MAX) begin
      q_d  = q_q + 1'b1;
      q_en = 1'b1;
    end else if (take && !req) begin
      q_d  = q_q - 1'b1;
      q_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign pending = (q_q != '0);

  p_take_queued_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> q_q != '0)
    else $error("rrdy sent with empty queue");
endmodule

// File: rtl/frame_tx_sched.sv
module frame_tx_sched
  import ftx_pkg::*;
#(
  parameter int CRED_W  = 8,
  parameter int GAP_MIN = 6,
  parameter int RQ_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRED_W-1:0] cfg_credit_limit,
  input  logic              link_reset,
  input  logic              rx_rrdy,
  input  logic              tx_rrdy_req,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic [31:0]       out_word,
  output logic              out_is_os
);
  ftx_state_e        state_q, state_d;
  logic [WORD_W-1:0] crc_q, crc_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              os_q, os_d;
  logic              crc_en;

  logic credit_ok, gap_done, rrdy_pending;
  logic start, discard, fill_sent, end_sent, rrdy_take;

  assign start   = (state_q == ST_FILL) && in_valid && in_sof && gap_done && credit_ok;
  assign discard = (state_q == ST_FILL) && in_valid && !in_sof;
  assign in_ready = (state_q == ST_BODY) || discard;

  always_comb begin
    state_d   = state_q;
    word_d    = OS_IDLE;
    os_d      = 1'b1;
    crc_d     = crc_q;
    crc_en    = 1'b0;
    fill_sent = 1'b0;
    end_sent  = 1'b0;
    rrdy_take = 1'b0;
    unique case (state_q)
      ST_FILL: begin
        if (start) begin
          word_d  = OS_SOF;
          crc_d   = '1;
          crc_en  = 1'b1;
          state_d = ST_BODY;
        end else begin
          fill_sent = 1'b1;
          if (rrdy_pending) begin
            word_d    = OS_RRDY;
            rrdy_take = 1'b1;
          end
        end
      end
      ST_BODY: begin
        if (in_valid) begin
          word_d = in_data;
          os_d   = 1'b0;
          crc_d  = crc_fold(crc_q, in_data);
          crc_en = 1'b1;
          if (in_eof) state_d = ST_CRC;
        end
      end
      ST_CRC: begin
        word_d  = ~crc_q;
        os_d    = 1'b0;
        state_d = ST_END;
      end
      ST_END: begin
        word_d   = OS_EOF;
        end_sent = 1'b1;
        state_d  = ST_FILL;
      end
      default: state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      word_q  <= OS_IDLE;
      os_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      os_q    <= os_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (crc_en) crc_q <= crc_d;
  end

  assign out_word  = word_q;
  assign out_is_os = os_q;

  ftx_credit #(.CRED_W(CRED_W)) u_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_reset  (link_reset),
    .frame_start (start),
    .rrdy_in     (rx_rrdy),
    .limit       (cfg_credit_limit),
    .credit_ok   (credit_ok)
  );

  ftx_gap #(.GAP_MIN(GAP_MIN)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_sent  (end_sent),
    .fill_sent (fill_sent),
    .gap_done  (gap_done)
  );

  ftx_rrdy_queue #(.RQ_W(RQ_W)) u_rrdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (tx_rrdy_req),
    .take    (rrdy_take),
    .pending (rrdy_pending)
  );

  p_ready_body_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BODY) |-> in_ready)
    else $error("ready low inside frame body");

  p_no_start_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && in_sof) |-> !in_ready)
    else $error("start word accepted outside body");

  p_sof_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && $past(state_q) == ST_FILL && !os_q) |-> 1'b0)
    else $error("data word outside a frame");

  p_no_rrdy_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BODY || state_q == ST_CRC) |=> !(os_q && word_q == OS_RRDY))
    else $error("rrdy emitted inside a frame");
endmodule

// File: tb/sim_frame_tx_sched.sv
module sim_frame_tx_sched;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 8192;
  localparam logic [31:0] W_IDLE = 32'hBC95B5B5;
  localparam logic [31:0] W_RRDY = 32'hBC954949;
  localparam logic [31:0] W_SOF  = 32'hBCB5E6E6;
  localparam logic [31:0] W_EOF  = 32'hBC95F5F5;

  // stimulus table: frame length, seed, stall position (-1 none)
  localparam int NVEC = 6;
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{1,  32'h1234_5678, -1},
    '{4,  32'h0000_0000, -1},
    '{7,  32'h7FFF_FFFF, -1},
    '{16, 32'h0BAD_F00D, -1},
    '{5,  32'h2468_ACE0, 2},
    '{3,  32'h5555_AAAA, 0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_limit;
  logic        link_reset, rx_rrdy, tx_rrdy_req;
  logic        in_valid, in_sof, in_eof;
  logic [31:0] in_data;
  logic        in_ready;
  logic [31:0] out_word;
  logic        out_is_os;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] logd [0:LOG_N-1];
  logic        logo [0:LOG_N-1];
  int          lp = 0;
  int          scan_pos = 0;
  logic [31:0] fw [0:63];
  int          fn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_tx_sched u0 (
    .clk(clk), .rst_n(rst_n), .cfg_credit_limit(cfg_limit),
    .link_reset(link_reset), .rx_rrdy(rx_rrdy), .tx_rrdy_req(tx_rrdy_req),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_ready(in_ready), .out_word(out_word), .out_is_os(out_is_os)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1 && lp < LOG_N) begin
      logd[lp] = out_word;
      logo[lp] = out_is_os;
      lp = lp + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 31; b >= 0; b--) begin
      if (r[31] ^ d[b]) r = (r << 1) ^ 32'h04C11DB7;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic int count_os(input int from, input logic [31:0] w);
    int n = 0;
    for (int i = from; i < lp; i++) if (logo[i] && logd[i] == w) n++;
    return n;
  endfunction

  function automatic int count_data(input int from);
    int n = 0;
    for (int i = from; i < lp; i++) if (!logo[i]) n++;
    return n;
  endfunction

  task automatic pulse_link_reset();
    @(negedge clk); link_reset = 1;
    @(negedge clk); link_reset = 0;
  endtask

  task automatic pulse_rx_rrdy();
    @(negedge clk); rx_rrdy = 1;
    @(negedge clk); rx_rrdy = 0;
  endtask

  task automatic send_frame(input int n, input logic [31:0] seed, input int stall_at);
    for (int i = 0; i < n; i++) fw[i] = seed ^ (32'h9E3779B9 * (i + 1)) ^ i;
    fn = n;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == stall_at && i != 0) begin
        in_valid = 0;
        repeat (2) @(negedge clk);
      end
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = fw[i];
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_frame(input string tag);
    int p, q, nd, bad;
    logic [31:0] crc, crcw;
    p = scan_pos;
    while (p < lp && !(logo[p] && logd[p] == W_SOF)) p++;
    chk({tag, " R2 start delimiter found"}, p < lp, 1);
    crc = '1; crcw = '0; nd = 0; bad = 0; q = p + 1;
    while (q < lp && !(logo[q] && logd[q] == W_EOF)) begin
      if (!logo[q]) begin
        if (nd < fn) begin
          if (logd[q] !== fw[nd]) bad++;
          crc = crc_step(crc, fw[nd]);
        end else if (nd == fn) crcw = logd[q];
        nd++;
      end else if (logd[q] != W_IDLE) bad++;
      q++;
    end
    chk({tag, " R2 end delimiter found"}, q < lp, 1);
    chk({tag, " R2 data word count"}, nd, fn + 1);
    chk({tag, " R2 body words in order"}, bad, 0);
    chk({tag, " R7 crc word"}, crcw, ~crc);
    scan_pos = q + 1;
  endtask

  initial begin
    int b, p, q;
    rst_n = 0; cfg_limit = 8'd8; link_reset = 0; rx_rrdy = 0; tx_rrdy_req = 0;
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset word", out_word, W_IDLE);
    chk("R1 reset tag", out_is_os, 1);
    chk("R1 reset ready", in_ready, 0);

    // table of frames
    for (int v = 0; v < NVEC; v++) begin
      scan_pos = lp;
      send_frame(VEC[v][0], VEC[v][1], VEC[v][2]);
      repeat (3) @(negedge clk);
      check_frame($sformatf("vec%0d R10", v));
    end

    // back-to-back gap
    pulse_link_reset();
    b = lp;
    send_frame(3, 32'hCAFE0001, -1);
    send_frame(2, 32'hCAFE0002, -1);
    repeat (3) @(negedge clk);
    p = b; while (p < lp && !(logo[p] && logd[p] == W_EOF)) p++;
    q = p + 1; while (q < lp && !(logo[q] && logd[q] == W_SOF)) q++;
    chk("R6 fill words between frames", q - p - 1, 6);

    // credit limit 2
    pulse_link_reset();
    cfg_limit = 8'd2;
    b = lp;
    send_frame(2, 32'h11110000, -1);
    send_frame(2, 32'h22220000, -1);
    fork
      send_frame(2, 32'h33330000, -1);
      begin
        repeat (30) @(negedge clk);
        chk("R3 third frame held at limit", count_os(b, W_SOF), 2);
        pulse_rx_rrdy();
      end
    join
    chk("R4 rrdy releases one frame", count_os(b, W_SOF), 3);

    // simultaneous start and rrdy
    pulse_link_reset();
    cfg_limit = 8'd2;
    b = lp;
    send_frame(2, 32'h44440000, -1);
    repeat (10) @(negedge clk);
    fork
      send_frame(2, 32'h55550000, -1);
      begin @(negedge clk); #2; rx_rrdy = 1; @(negedge clk); rx_rrdy = 0; end
    join
    fork
      send_frame(2, 32'h66660000, -1);
      begin
        repeat (30) @(negedge clk);
        chk("R5 same-cycle start and rrdy keep count", count_os(b, W_SOF), 3);
        pulse_rx_rrdy();
      end
    join

    // rrdy at zero saturates
    pulse_link_reset();
    repeat (3) pulse_rx_rrdy();
    cfg_limit = 8'd1;
    b = lp;
    fork
      send_frame(2, 32'h77770000, -1);
      begin
        repeat (30) @(negedge clk);
        chk("R5 no underflow at zero", count_os(b, W_SOF), 1);
        if (count_os(b, W_SOF) == 0) pulse_link_reset();
      end
    join
    fork
      send_frame(2, 32'h88880000, -1);
      begin
        repeat (30) @(negedge clk);
        chk("R3 held at limit one", count_os(b, W_SOF), 1);
        pulse_link_reset();
      end
    join
    chk("R9 link reset frees credit", count_os(b, W_SOF), 2);

    // limit zero
    pulse_link_reset();
    cfg_limit = 8'd0;
    b = lp;
    fork
      send_frame(2, 32'h99990000, -1);
      begin
        repeat (30) @(negedge clk);
        chk("R3 limit zero blocks start", count_os(b, W_SOF), 0);
        #1;
        chk("R3 ready low at limit zero", in_ready, 0);
        cfg_limit = 8'd1;
      end
    join
    chk("R3 start after limit raised", count_os(b, W_SOF), 1);

    // stray word outside a frame
    pulse_link_reset();
    cfg_limit = 8'd1;
    repeat (10) @(negedge clk);
    b = lp;
    @(negedge clk);
    in_valid = 1; in_sof = 0; in_eof = 0; in_data = 32'hDEADBEEF;
    #1;
    chk("R11 stray word accepted", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    repeat (5) @(negedge clk);
    chk("R11 stray word not sent", count_data(b), 0);
    scan_pos = lp;
    send_frame(3, 32'hABCD0000, -1);
    repeat (3) @(negedge clk);
    chk("R11 stray word took no credit", count_os(b, W_SOF), 1);
    check_frame("R11 frame after stray");

    // receiver-ready queue
    pulse_link_reset();
    cfg_limit = 8'd4;
    repeat (10) @(negedge clk);
    b = lp;
    @(negedge clk); tx_rrdy_req = 1;
    @(negedge clk); @(negedge clk); tx_rrdy_req = 0;
    repeat (6) @(negedge clk);
    chk("R8 two queued rrdy words sent", count_os(b, W_RRDY), 2);
    repeat (10) @(negedge clk);
    b = lp;
    scan_pos = lp;
    fork
      send_frame(10, 32'h0F0F0000, -1);
      begin
        repeat (5) @(negedge clk);
        tx_rrdy_req = 1; @(negedge clk); tx_rrdy_req = 0;
      end
    join
    repeat (3) @(negedge clk);
    check_frame("R8 frame with rrdy request");
    chk("R8 rrdy sent after end delimiter", count_os(scan_pos, W_RRDY), 1);
    chk("R8 one rrdy in total", count_os(b, W_RRDY), 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule